// File: doc/BRIEF.md
# Exclusion-Masked Random Tag Generator

This block produces a 4-bit pseudo-random tag to place in the top byte of a pointer. When a caller pulses a request, the block takes a candidate from a free-running 16-bit linear feedback shift register (LFSR). It then checks the candidate against a 16-bit exclusion bitmap. Bit `n` of the bitmap forbids tag value `n`. If the candidate is forbidden, the block searches upward, wrapping modulo 16, and takes the first permitted value. The search is done in one cycle, so the result is always ready one cycle after the request.

The block returns the tag on its own and also inside a copy of the input pointer, at bits 59:56. It raises a one-cycle done strobe with the result. Software can reseed the LFSR through a load port.

Top module: `rtag_gen`

## Requirements
- R1: After a request whose exclusion mask is not all ones, `tag_o` is a value whose bit in that mask was 0.
- R2: After a request with exclusion mask 16'hFFFF, `tag_o` is 0.
- R3: The candidate for a request is bits 3:0 of the LFSR state in the request cycle. If the candidate's mask bit is 0, the candidate is the tag.
- R4: If the candidate is excluded, the tag is the first permitted value found by counting upward from the candidate, wrapping from 15 to 0.
- R5: With the default exclusion mask 16'hFFFE, every request returns tag 0.
- R6: After a request, `ptr_o[59:56]` equals the new tag. Every other bit of `ptr_o` equals `ptr_i` as sampled in the request cycle.
- R7: `done_o` is high in exactly the cycle after each request cycle and low otherwise. `tag_o` and `ptr_o` keep their values when there is no request.
- R8: The LFSR shifts left: the next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. It steps once per request and holds otherwise.
- R9: Reset is synchronous and active low. It sets the LFSR to 16'hACE1, and `tag_o`, `ptr_o` and `done_o` to 0.
- R10: `seed_wr_i` loads `seed_i` into the LFSR, and a seed of 0 is replaced by 16'h0001. A load takes priority over a request's step in the same cycle, and that request still uses the old state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request a new tag this cycle |
| excl_mask_i | input | 16 | Exclusion bitmap, bit n forbids tag n |
| ptr_i | input | 64 | Pointer to receive the tag |
| seed_wr_i | input | 1 | Load the LFSR from seed_i |
| seed_i | input | 16 | Seed value |
| tag_o | output | 4 | Generated tag |
| done_o | output | 1 | Result valid, one cycle after request |
| ptr_o | output | 64 | Pointer with bits 59:56 replaced by the tag |

## Verification
The assertions check these properties on every cycle:
- the result never lands on an excluded tag;
- an all-ones mask forces tag 0;
- the pointer field carries the tag and the other bits pass through;
- the done pulse timing, and outputs and LFSR state holding between requests;
- the zero-seed substitution.

Some properties only the bench's cycle-by-cycle reference model can show:
- the exact tag sequence from a given seed;
- the wrap-around in the upward search;
- a load winning over a step in the same cycle;
- the LFSR value after reset.

// File: rtl/rtag_pkg.sv
// Shared constants and types for the random tag generator.
// Assumes tags are 4 bits, so the exclusion bitmap has 16 entries.
package rtag_pkg;
    localparam int TAG_W    = 4;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int LFSR_W   = 16;
    localparam logic [LFSR_W-1:0] LFSR_RESET = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_ZSUB  = 16'h0001;
    localparam logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400;
    localparam logic [NUM_TAGS-1:0] DEFAULT_EXCL = 16'hFFFE;
    typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/rtag_lfsr.sv
// Left-shifting Fibonacci LFSR with a load port.
// A load wins over a step. A zero seed is replaced by SUB so the state never locks up.
// Assumes TAPS describes a maximal-length polynomial for width W.
module rtag_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '1,
    parameter logic [W-1:0] SUB     = 1,
    parameter logic [W-1:0] TAPS    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic         fb;

    // Feedback bit: XOR of the tapped state bits.
    always_comb fb = ^(state_q & TAPS);

    // State update: reset, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RST_VAL;
        else if (load_i)
            state_q <= (seed_i == '0) ? SUB : seed_i;
        else if (step_i)
            state_q <= {state_q[W-2:0], fb};
    end

    assign state_o = state_q;

    p_lfsr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> state_q == $past(state_q));
    p_lfsr_zero_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> state_q == SUB);
    p_lfsr_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/rtag_pick.sv
// One-cycle search for a permitted tag.
// The permit vector is rotated so the candidate sits at position 0. A priority
// pick finds the lowest permitted offset, and the tag is candidate plus offset
// (modulo NUM_TAGS). With nothing permitted, the tag is 0.
module rtag_pick
    import rtag_pkg::*;
(
    input  tag_t                cand_i,
    input  logic [NUM_TAGS-1:0] excl_i,
    output tag_t                tag_o
);
    logic [NUM_TAGS-1:0] rot;
    tag_t                off;
    logic                any;

    // Rotate the permit vector so that entry k stands for tag cand_i + k.
    for (genvar k = 0; k < NUM_TAGS; k++) begin : g_rot
        assign rot[k] = ~excl_i[cand_i + tag_t'(k)];
    end

    // Priority pick of the lowest permitted offset.
    always_comb begin
        off = '0;
        any = 1'b0;
        for (int k = NUM_TAGS - 1; k >= 0; k--) begin
            if (rot[k]) begin
                off = tag_t'(k);
                any = 1'b1;
            end
        end
    end

    // Final tag: wrap-around add, or 0 when every tag is excluded.
    always_comb tag_o = any ? tag_t'(cand_i + off) : '0;

    // Immediate checks on the combinational result.
    always_comb begin
        if (excl_i != '1)
            p_pick_allowed_r1: assert (!excl_i[tag_o]);
        if (!excl_i[cand_i])
            p_pick_direct_r3: assert (tag_o == cand_i);
    end
endmodule

// File: rtl/rtag_gen.sv
// Top-level random tag generator.
// A request samples the LFSR candidate, the exclusion mask and the pointer.
// One cycle later it presents the tag, the pointer with the tag inserted, and
// a done pulse. The LFSR steps once per request. Outputs hold between requests.
// Assumes the tag field fits inside PTR_W.
module rtag_gen
    import rtag_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int TAG_LSB = 56
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [NUM_TAGS-1:0] excl_mask_i,
    input  logic [PTR_W-1:0]    ptr_i,
    input  logic                seed_wr_i,
    input  logic [LFSR_W-1:0]   seed_i,
    output logic [TAG_W-1:0]    tag_o,
    output logic                done_o,
    output logic [PTR_W-1:0]    ptr_o
);
    localparam logic [PTR_W-1:0] FIELD = {{(PTR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

    logic [LFSR_W-1:0] lfsr_state;
    tag_t              pick_tag;
    logic [PTR_W-1:0]  ptr_next;
    tag_t              tag_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              done_q;

    rtag_lfsr #(
        .W       (LFSR_W),
        .RST_VAL (LFSR_RESET),
        .SUB     (LFSR_ZSUB),
        .TAPS    (LFSR_TAPS)
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (seed_wr_i),
        .seed_i  (seed_i),
        .step_i  (req_i),
        .state_o (lfsr_state)
    );

    rtag_pick pick_i (
        .cand_i (lfsr_state[TAG_W-1:0]),
        .excl_i (excl_mask_i),
        .tag_o  (pick_tag)
    );

    // Insert the chosen tag into the pointer's tag field.
    always_comb begin
        ptr_next = ptr_i;
        ptr_next[TAG_LSB +: TAG_W] = pick_tag;
    end

    // Result registers: capture on request, raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= req_i;
            if (req_i) begin
                tag_q <= pick_tag;
                ptr_q <= ptr_next;
            end
        end
    end

    assign tag_o  = tag_q;
    assign ptr_o  = ptr_q;
    assign done_o = done_q;

    p_excl_honoured_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && excl_mask_i != '1) |=> (($past(excl_mask_i) >> tag_o) & 1) == 0);
    p_all_excl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && excl_mask_i == '1) |=> tag_o == '0);
    p_ptr_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ptr_o[TAG_LSB +: TAG_W] == tag_o);
    p_ptr_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ((ptr_o ^ $past(ptr_i)) & ~FIELD) == '0);
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);
    p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(tag_o) && $stable(ptr_o)));
endmodule

// File: tb/rtag_gen_tb_top.sv
module rtag_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] mask = 16'h0;
    logic [63:0] ptr = 64'h0;
    logic        seed_wr = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [3:0]  tag_o;
    logic        done_o;
    logic [63:0] ptr_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rtag_gen dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req), .excl_mask_i (mask),
        .ptr_i (ptr), .seed_wr_i (seed_wr), .seed_i (seed),
        .tag_o (tag_o), .done_o (done_o), .ptr_o (ptr_o)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Behavioural reference model.
    int          m_lfsr;
    logic [3:0]  e_tag;
    logic [63:0] e_ptr;
    logic        e_done;
    logic [15:0] e_mask;
    string       e_lbl = "R9";
    bit          mvalid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 'hACE1; e_tag = 0; e_ptr = 0; e_done = 0; e_lbl = "R9";
            mvalid = 1'b1;
        end else begin
            e_done = req;
            if (req) begin
                int cand;
                int t;
                cand = m_lfsr % 16;
                t = -1;
                for (int k = 0; k < 16; k++)
                    if (t < 0 && !mask[(cand + k) % 16]) t = (cand + k) % 16;
                if (t < 0) t = 0;
                e_tag = t[3:0];
                e_ptr = (ptr & ~(64'hF << 56)) | (64'(t) << 56);
                e_mask = mask;
                if (mask == 16'hFFFF) e_lbl = "R2";
                else if (mask == 16'hFFFE) e_lbl = "R5";
                else if (mask == 16'h0) e_lbl = "R8";
                else if (mask[cand]) e_lbl = "R4";
                else e_lbl = "R3";
            end
            if (seed_wr) m_lfsr = (seed == 0) ? 1 : int'(seed);
            else if (req) begin
                int fb;
                fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
                m_lfsr = ((m_lfsr << 1) & 'hFFFF) | fb;
            end
        end
    end

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (mvalid && !finished) begin
            chk(done_o == e_done, "R7 done", 64'(done_o), 64'(e_done));
            chk(tag_o == e_tag, e_lbl, 64'(tag_o), 64'(e_tag));
            chk(ptr_o == e_ptr, "R6 ptr", ptr_o, e_ptr);
            if (done_o && e_mask != 16'hFFFF)
                chk(!e_mask[tag_o], "R1 excluded tag", 64'(tag_o), 64'(e_tag));
        end
    end

    task automatic step(input bit r, input logic [15:0] m, input logic [63:0] p,
                        input bit sw, input logic [15:0] s);
        req = r; mask = m; ptr = p; seed_wr = sw; seed = s;
        @(negedge clk);
        req = 1'b0; seed_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tag_o == 0 && ptr_o == 0 && done_o == 0, "R9 reset outputs",
            {ptr_o[59:0], tag_o}, 64'h0);
        rst_n = 1'b1;
        step(1, 16'h0000, 64'h0123_4567_89AB_CDEF, 0, 0);
        chk(tag_o == 4'h1, "R9 reset seed", 64'(tag_o), 64'h1);
        step(0, 16'h0, 64'h0, 0, 0);
        chk(done_o == 1'b0, "R7 idle", 64'(done_o), 64'h0);
        step(1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        chk(tag_o == 0, "R2 all excluded", 64'(tag_o), 64'h0);
        step(1, 16'hFFFE, 64'hA5A5_A5A5_A5A5_A5A5, 0, 0);
        chk(tag_o == 0, "R5 default mask", 64'(tag_o), 64'h0);
        step(0, 16'h0, 64'h0, 1, 16'h0000);
        step(1, 16'h0000, 64'h0, 0, 0);
        chk(tag_o == 4'h1, "R10 zero seed", 64'(tag_o), 64'h1);
        step(1, 16'h0000, 64'h0, 0, 0);
        chk(tag_o == 4'h2, "R8 step", 64'(tag_o), 64'h2);
        step(1, 16'h0000, 64'h0, 1, 16'h1234);
        step(1, 16'h0000, 64'h0, 0, 0);
        chk(tag_o == 4'h4, "R10 load beats step", 64'(tag_o), 64'h4);
        step(0, 16'h0, 64'h0, 1, 16'h000F);
        step(1, 16'hFFFB, 64'h0, 0, 0);
        chk(tag_o == 4'h2, "R4 wrap search", 64'(tag_o), 64'h2);
        for (int i = 0; i < 400; i++) begin
            logic [15:0] m;
            case (i % 6)
                0: m = 16'h0000;
                1: m = 16'(~(16'h1 << ($urandom % 16)));
                2: m = 16'($urandom);
                3: m = 16'hFFFE;
                4: m = 16'hFFFF;
                default: m = 16'hFF00 | 16'($urandom % 256);
            endcase
            step(($urandom % 4) != 0, m, {$urandom, $urandom}, ($urandom % 23) == 0,
                 16'($urandom % 3 == 0 ? 0 : $urandom));
        end
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule